// File: doc/BRIEF.md
# Two-Stage Sigma-Delta Bitstream Decimator

This block converts the single-bit output of a sigma-delta modulator into 16-bit two's-complement samples. Each modulator bit arrives with a one-cycle enable strobe. A bit of 1 counts as +1 and a bit of 0 counts as -1. A third-order cascaded integrator-comb filter first reduces the rate by a fixed factor of 32. An averaging stage then reduces it again by 2, 4 or 8, as a 2-bit ratio select chooses while the block runs.

The averaged value is scaled so that the full span of the modulator maps onto the signed 16-bit range. A steady stream of ones gives +32767 and a steady stream of zeros gives -32768. A balanced stream gives 0, and a half-scale stream gives +16383 or -16384. Each new sample is announced by a single-cycle valid pulse, and the output holds its value between pulses. When the ratio select changes, the averaging stage starts over. No sample leaves until a complete window at the new ratio has been gathered.

Top module: `sdd_decimator`

## Requirements
- R1: While reset is held low on a clock edge, and on the cycles after it until the first new sample, `sample_out` is 0 and `sample_vld` is low.
- R2: A modulator bit is taken only on a cycle with `bit_en` high, where 1 counts as +1 and 0 as -1. The value of `mod_bit` on cycles with `bit_en` low has no effect on any output sample.
- R3: The first stage is a third-order integrator-comb filter decimating by 32, with a DC gain of 32768. It produces one intermediate sample per 32 strobes. Its first two intermediate samples after reset are partial and are discarded.
- R4: `osr_sel` encodes the second-stage ratio N as 00 = 2, 01 = 4, 10 = 8 and 11 = 8. In steady operation, output samples are exactly N*32 strobes apart.
- R5: After reset, the first output sample comes from strobe number (2+N)*32, counting from the first strobe after reset.
- R6: The output equals floor(A*65535/65536), where A is the arithmetic mean of the last N first-stage samples, clamped to -32768..32767. A stream with a fraction f of ones in every 32-bit period therefore gives A = 32768*(2f-1).
- R7: `sample_vld` is high for exactly one clock cycle per sample. `sample_out` changes only on the cycle that `sample_vld` rises.
- R8: A change of `osr_sel` clears the averaging stage. The next sample is produced only after N new first-stage samples, at the new N, have arrived after the change.
- R9: `sample_vld` rises on the third clock edge after the edge that samples the strobe completing an output window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Strobe marking a cycle that carries a modulator bit |
| mod_bit | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| osr_sel | input | 2 | Second-stage ratio select (00=2, 01=4, 10=8, 11=8) |
| sample_out | output | 16 | Decimated signed sample |
| sample_vld | output | 1 | One-cycle pulse marking a new sample |

## Verification
The embedded properties check the following on every cycle:
- the integrators stay still when no bit is strobed;
- the intermediate samples stay within the first-stage full scale;
- a ratio change restarts the averaging;
- the valid pulse is a single cycle;
- the output is held between pulses;
- zero and positive full scale map to their fixed codes.

The exact code for each duty-cycle pattern depends on the filter arithmetic over whole windows, so only the bench scenarios can show it. The same holds for the strobe count to the first sample, the spacing at every ratio select (including the reserved value), the three-edge latency, and the restart timing after a mid-window ratio change. The bench sweeps every ratio select against a set of periodic streams and fills the cycles without a strobe with unrelated bits.

// File: rtl/sdd_pkg.sv
// Shared constants and helpers for the two-stage decimator.
// Assumes a 2-bit ratio select; the reserved code behaves as the largest ratio.
package sdd_pkg;

    // Largest second-stage shift (log2 of the largest ratio).
    localparam int OSR_SH_MAX = 3;

    // Map the ratio select onto log2 of the second-stage ratio.
    function automatic logic [1:0] osr_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2'd1;
            2'b01:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/sdd_cic.sv
// First stage: order-ORDER integrator-comb decimator by 2**R_LOG2.
// Takes one +1/-1 input per bit_en strobe. It emits one intermediate sample per
// 2**R_LOG2 strobes and drops the first ORDER-1 partial ones after reset.
// Assumes strobes are at least two clock cycles apart.
module sdd_cic #(
    parameter int R_LOG2 = 5,
    parameter int ORDER  = 3,
    parameter int W      = 2 + ORDER * R_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                mod_bit,
    output logic signed [W-1:0] s1_data,
    output logic                s1_vld
);

    localparam int WARM   = ORDER - 1;
    localparam int WARM_W = $clog2(ORDER + 1);
    localparam logic signed [W-1:0] FS = W'(1) << (ORDER * R_LOG2);

    logic signed [W-1:0] integ [ORDER];
    logic signed [W-1:0] dly   [ORDER];
    logic signed [W-1:0] diff  [ORDER];
    logic signed [W-1:0] x_in;
    logic [R_LOG2-1:0]   phase;
    logic                take;
    logic [WARM_W-1:0]   warm;

    // Map the modulator bit to +1 or -1 at full width.
    assign x_in = {{(W-1){~mod_bit}}, 1'b1};

    // Integrator chain and decimation phase, advanced only on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) integ[k] <= '0;
            phase <= '0;
            take  <= 1'b0;
        end else begin
            take <= bit_en && (phase == '1);
            if (bit_en) begin
                phase <= phase + 1'b1;
                for (int k = 0; k < ORDER; k++)
                    integ[k] <= integ[k] + ((k == 0) ? x_in : integ[(k == 0) ? 0 : k-1]);
            end
        end
    end

    // Comb chain differences, evaluated at the decimated rate.
    always_comb begin
        diff[0] = integ[ORDER-1] - dly[0];
        for (int k = 1; k < ORDER; k++) diff[k] = diff[k-1] - dly[k];
    end

    // Comb delay registers, intermediate output and warm-up suppression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
            s1_data <= '0;
            s1_vld  <= 1'b0;
            warm    <= '0;
        end else begin
            s1_vld <= 1'b0;
            if (take) begin
                dly[0] <= integ[ORDER-1];
                for (int k = 1; k < ORDER; k++) dly[k] <= diff[k-1];
                s1_data <= diff[ORDER-1];
                if (warm == WARM_W'(WARM)) s1_vld <= 1'b1;
                else                       warm   <= warm + 1'b1;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(integ[0])); // R2

    AST_S1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |-> (s1_data <= FS && s1_data >= -FS)); // R3

endmodule

// File: rtl/sdd_avg.sv
// Second stage: averages N first-stage samples, where N = 2**osr_shift(osr_sel).
// A change of osr_sel discards the partial window and restarts the count.
// Assumes first-stage samples arrive at least two cycles apart.
module sdd_avg
    import sdd_pkg::*;
#(
    parameter int IN_W = 17
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             osr_sel,
    input  logic signed [IN_W-1:0] s1_data,
    input  logic                   s1_vld,
    output logic signed [IN_W-1:0] avg_data,
    output logic                   avg_vld
);

    localparam int SUM_W = IN_W + OSR_SH_MAX;

    logic [1:0]             osr_q;
    logic                   chg;
    logic [1:0]             sh;
    logic [OSR_SH_MAX-1:0]  cnt;
    logic [OSR_SH_MAX-1:0]  n_last;
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] sum_next;
    logic signed [SUM_W-1:0] mean;

    // Ratio decode, change detection and the running sum.
    always_comb begin
        chg      = (osr_sel != osr_q);
        sh       = osr_shift(osr_q);
        n_last   = OSR_SH_MAX'((1 << sh) - 1);
        sum_next = acc + {{OSR_SH_MAX{s1_data[IN_W-1]}}, s1_data};
        mean     = sum_next >>> sh;
    end

    // Window accumulation, restart on a ratio change, and the averaged output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr_q    <= osr_sel;
            acc      <= '0;
            cnt      <= '0;
            avg_data <= '0;
            avg_vld  <= 1'b0;
        end else begin
            osr_q   <= osr_sel;
            avg_vld <= 1'b0;
            if (chg) begin
                acc <= '0;
                cnt <= '0;
            end else if (s1_vld) begin
                if (cnt == n_last) begin
                    avg_data <= mean[IN_W-1:0];
                    avg_vld  <= 1'b1;
                    acc      <= '0;
                    cnt      <= '0;
                end else begin
                    acc <= sum_next;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_OSR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_sel != osr_q) |=> (cnt == '0 && !avg_vld)); // R8

endmodule

// File: rtl/sdd_scale.sv
// Output stage: scales the mean by (2**OUT_W-1)/2**(GAIN_LOG2+1), floors the
// result and clamps it to the signed OUT_W range in a registered output.
// Assumes the input magnitude never exceeds 2**GAIN_LOG2.
module sdd_scale #(
    parameter int IN_W      = 17,
    parameter int OUT_W     = 16,
    parameter int GAIN_LOG2 = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic                    in_vld,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_vld
);

    localparam int PW = IN_W + OUT_W + 1;
    localparam int SH = GAIN_LOG2 + 1;
    localparam logic signed [PW-1:0]   MAXV = PW'((64'sd1 <<< (OUT_W-1)) - 1);
    localparam logic signed [PW-1:0]   MINV = -MAXV - 1;
    localparam logic signed [IN_W-1:0] FSIN = IN_W'(1) << GAIN_LOG2;
    localparam logic signed [OUT_W-1:0] OMAX = MAXV[OUT_W-1:0];

    logic signed [PW-1:0] ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] q;

    // Multiply by (2**OUT_W - 1) as a shift and subtract, then floor-shift.
    always_comb begin
        ext  = {{(PW-IN_W){in_data[IN_W-1]}}, in_data};
        prod = (ext <<< OUT_W) - ext;
        q    = prod >>> SH;
    end

    // Clamp and register the sample together with its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                if (q > MAXV)      out_data <= MAXV[OUT_W-1:0];
                else if (q < MINV) out_data <= MINV[OUT_W-1:0];
                else               out_data <= q[OUT_W-1:0];
            end
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld); // R7

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_data)); // R7

    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_data == '0) |=> (out_data == '0)); // R6

    AST_FULL_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_data == FSIN) |=> (out_data == OMAX)); // R6

endmodule

// File: rtl/sdd_decimator.sv
// Top: two-stage decimator from a 1-bit modulator stream to signed OUT_W samples.
// The first stage is a fixed CIC decimating by 2**R_LOG2. It is followed by a
// selectable averager and a scaling stage.
// Assumes bit_en strobes are at least two cycles apart.
module sdd_decimator #(
    parameter int R_LOG2 = 5,
    parameter int ORDER  = 3,
    parameter int OUT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             mod_bit,
    input  logic [1:0]       osr_sel,
    output logic [OUT_W-1:0] sample_out,
    output logic             sample_vld
);

    localparam int GAIN_LOG2 = ORDER * R_LOG2;
    localparam int W         = 2 + GAIN_LOG2;

    logic signed [W-1:0]     s1_data;
    logic                    s1_vld;
    logic signed [W-1:0]     avg_data;
    logic                    avg_vld;
    logic signed [OUT_W-1:0] out_s;

    sdd_cic #(.R_LOG2(R_LOG2), .ORDER(ORDER), .W(W)) u_cic (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .mod_bit (mod_bit),
        .s1_data (s1_data),
        .s1_vld  (s1_vld)
    );

    sdd_avg #(.IN_W(W)) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .osr_sel  (osr_sel),
        .s1_data  (s1_data),
        .s1_vld   (s1_vld),
        .avg_data (avg_data),
        .avg_vld  (avg_vld)
    );

    sdd_scale #(.IN_W(W), .OUT_W(OUT_W), .GAIN_LOG2(GAIN_LOG2)) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (avg_data),
        .in_vld   (avg_vld),
        .out_data (out_s),
        .out_vld  (sample_vld)
    );

    assign sample_out = out_s;

endmodule

// File: tb/sdd_decimator_test.sv
module sdd_decimator_test;

    localparam int CLK_PERIOD = 10;
    localparam int STROBE_GAP = 8;
    localparam int WDOG       = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic [1:0]  osr_sel = 2'b00;
    logic [15:0] sample_out;
    logic        sample_vld;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] last_out = '0;
    int hold_err = 0;

    sdd_decimator uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .mod_bit    (mod_bit),
        .osr_sel    (osr_sel),
        .sample_out (sample_out),
        .sample_vld (sample_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected code for a pattern with 'ones' ones in each 'plen' bits (R6).
    function automatic longint expect_code(input int ones, input int plen);
        longint a, num, y;
        a   = (64'sd32768 * (2 * ones - plen)) / plen;
        num = a * 65535;
        y   = num / 65536;
        if (num < 0 && (num % 65536) != 0) y = y - 1;
        if (y > 32767)  y = 32767;
        if (y < -32768) y = -32768;
        return y;
    endfunction

    function automatic int ratio_of(input logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    endfunction

    // One strobe, then unrelated bits on idle cycles; reports where valid was seen.
    task automatic strobe_step(input logic b, output int vidx, output int vcnt,
                               output logic [15:0] vval);
        vidx = 0; vcnt = 0; vval = '0;
        @(negedge clk);
        bit_en  = 1'b1;
        mod_bit = b;
        for (int i = 1; i < STROBE_GAP; i++) begin
            @(negedge clk);
            if (sample_vld) begin
                if (vcnt == 0) begin vidx = i; vval = sample_out; end
                vcnt++;
                last_out = sample_out;
            end else if (sample_out != last_out) begin
                hold_err++;
            end
            bit_en  = 1'b0;
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mod_bit = lfsr[0];
        end
    endtask

    task automatic do_reset(input logic [1:0] osr);
        @(negedge clk);
        rst_n   = 1'b0;
        bit_en  = 1'b0;
        osr_sel = osr;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sample_out after reset", sample_out, 0);
        chk("R1 sample_vld after reset", sample_vld, 0);
        last_out = '0;
        hold_err = 0;
    endtask

    task automatic run_pattern(input logic [1:0] osr, input logic [7:0] pat,
                               input int plen, input int nout);
        int n, k, got, exp_k, ones, vidx, vcnt;
        logic [15:0] vval;
        longint y;
        do_reset(osr);
        n = ratio_of(osr);
        ones = 0;
        for (int i = 0; i < plen; i++) ones += pat[i];
        y = expect_code(ones, plen);
        k = 0; got = 0;
        exp_k = (2 + n) * 32;
        while (got < nout) begin
            strobe_step(pat[k % plen], vidx, vcnt, vval);
            k++;
            if (vcnt > 0) begin
                chk("R9 valid latency", vidx, 4);
                chk("R7 single-cycle valid", vcnt, 1);
                if (got == 0) chk("R5 first sample strobe (R3 warm-up)", k, exp_k);
                else          chk("R4 sample spacing", k, exp_k);
                chk("R6 sample value (R2 bit mapping)", longint'($signed(vval)), y);
                got++;
                exp_k += n * 32;
            end else if (k > exp_k) begin
                chk("R4 missing sample", k, exp_k);
                got = nout;
            end
        end
        chk("R7 output held between pulses", hold_err, 0);
    endtask

    task automatic run_osr_change();
        int k, got, vidx, vcnt;
        int exp_list [3];
        logic [15:0] vval;
        exp_list[0] = 192; exp_list[1] = 480; exp_list[2] = 736;
        do_reset(2'b01);
        k = 0; got = 0;
        while (got < 3 && k < 800) begin
            strobe_step(1'b1, vidx, vcnt, vval);
            k++;
            if (k == 230) osr_sel = 2'b10;
            if (vcnt > 0) begin
                chk("R8 strobe of sample around ratio change", k, exp_list[got]);
                chk("R8 value after ratio change", longint'($signed(vval)), 32767);
                got++;
            end
        end
        chk("R8 samples seen after ratio change", got, 3);
        chk("R7 output held around ratio change", hold_err, 0);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            logic [1:0] osr;
            osr = 2'(s);
            run_pattern(osr, 8'h01, 1, 3);
            run_pattern(osr, 8'h00, 1, 3);
            run_pattern(osr, 8'h01, 2, 3);
            run_pattern(osr, 8'h07, 4, 3);
            run_pattern(osr, 8'h01, 4, 3);
            run_pattern(osr, 8'h7F, 8, 3);
            run_pattern(osr, 8'h01, 8, 3);
        end
        run_osr_change();
        do_reset(2'b00);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule